// File: doc/BRIEF.md
# Queued Interrupt Identity Register Bank

This block collects single-cycle event pulses from a parameterised number of sources (32 by default) and presents them to a host through a small register port. There are three host-visible registers. The mask register decides which sources may record an event. The enable register decides which recorded events drive the interrupt line. The identity register holds the recorded events and is cleared by writing ones.

Each identity bit can keep one further event waiting behind the one that software sees. When software clears a bit that has a waiting event, the waiting event moves into the visible position. Software must therefore clear a bit twice to be sure it is empty. The interrupt line is a registered level. It is high whenever any identity bit is set together with its enable bit.

Writes take effect on the clock edge that samples them. Reads are combinational from the address and change nothing. The intended bring-up order is:
1. Check that the identity register is zero.
2. Program the enable register.
3. Program the mask register.

Top module: `qirq_bank`

## Requirements
- R1: After reset the identity register reads 0, the mask register reads all ones, the enable register reads 0 and `irqOut` is low.
- R2: An event pulse on a source whose mask bit is 1 is dropped: it neither sets the identity bit nor waits behind it. With the mask bit at 0 the event sets the identity bit at the next edge.
- R3: Writing the identity register (address 0) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: An accepted event on a bit that is already set is held as a waiting event. Clearing that bit makes it read as set again, and a second clear leaves it at 0. An event arriving while a bit is set and already has a waiting event is lost.
- R5: When an accepted event and a clear of the same bit happen in the same cycle, the clear is ignored and the event is recorded as if no clear had been written.
- R6: `irqOut` equals the OR over all bits of (identity AND enable), sampled one clock after those register values.
- R7: With the enable register at 0, `irqOut` is low whatever the identity bits hold. Writing the enable register back while identity bits are set, including bits promoted from the waiting slot, raises `irqOut` again.
- R8: Reading any register has no side effect: repeated reads return the same value and no state changes.
- R9: The register map is: address 0 for identity, address 1 for mask, address 2 for enable. Address 3 reads 0, and writes to address 3 change nothing.
- R10: A write to the mask or enable register replaces its whole value, and the new value reads back from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcEvent | input | NSRC | One-cycle event pulses, one per source |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | NSRC | Write data |
| regRdData | output | NSRC | Read data for `regAddr` (combinational) |
| irqOut | output | 1 | Registered interrupt level |

## Verification
Directed sequences cover the following cases, each chosen because it separates one possible fault from the rest:
- A single event, which separates plain latching from queueing.
- A double event followed by two clears, which shows whether the waiting slot exists and whether it is promoted.
- An event that coincides with a clear, which settles which of the two wins.
- A triple event, which shows that a full bit drops further events.
- A write of zeros to the identity register, which tells write-one-to-clear apart from a plain write.
- Masked and partially masked bursts, which show that a blocked event is neither recorded nor queued.
- Enable toggling with bits still pending, which checks that the line falls and then rises again.

Sparse random event bursts mixed with random register writes are then checked against a cycle model. This exercises the cases above interleaved across many bits at once.

// File: rtl/qirq_pkg.sv
package qirq_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_IDENT  = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic wrMask;
    logic wrEnable;
    logic clrIdent;
  } bankStrobe_t;
endpackage

// File: rtl/qirq_ctrl.sv
module qirq_ctrl
  import qirq_pkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output bankStrobe_t       stb,
  output regSel_e           rdSel
);
  always_comb begin
    rdSel        = regSel_e'(regAddr);
    stb          = '0;
    if (regWrEn) begin
      unique case (rdSel)
        SEL_IDENT:  stb.clrIdent = 1'b1;
        SEL_MASK:   stb.wrMask   = 1'b1;
        SEL_ENABLE: stb.wrEnable = 1'b1;
        default:    stb          = '0;
      endcase
    end
  end
endmodule

// File: rtl/qirq_cell.sv
module qirq_cell (
  input  logic clk,
  input  logic rstN,
  input  logic evIn,
  input  logic maskBit,
  input  logic clrIn,
  output logic visOut,
  output logic qdOut
);
  logic visQ, qdQ, visD, qdD, accept;

  assign accept = evIn & ~maskBit;

  always_comb begin
    visD = visQ;
    qdD  = qdQ;
    if (accept) begin
      if (!visQ) visD = 1'b1;
      else       qdD  = 1'b1;
    end else if (clrIn) begin
      visD = qdQ;
      qdD  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      visQ <= 1'b0;
      qdQ  <= 1'b0;
    end else begin
      visQ <= visD;
      qdQ  <= qdD;
    end
  end

  assign visOut = visQ;
  assign qdOut  = qdQ;

  // R2
  masked_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evIn && maskBit && !visQ) |=> !visQ);
  // R4
  queue_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evIn && !maskBit && visQ) |=> (visQ && qdQ));
  // R4
  queue_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    qdQ |-> visQ);
  // R3
  clear_promote_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrIn && !(evIn && !maskBit)) |=> (!qdQ && (visQ == $past(qdQ))));
  // R5
  event_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evIn && !maskBit && clrIn) |=> visQ);
endmodule

// File: rtl/qirq_datapath.sv
module qirq_datapath
  import qirq_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] srcEvent,
  input  bankStrobe_t     stb,
  input  regSel_e         rdSel,
  input  logic [NSRC-1:0] wrData,
  output logic [NSRC-1:0] rdData,
  output logic            irqOut
);
  logic [NSRC-1:0] imrQ, ierQ, identVis, identQd;
  logic            irqQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      imrQ <= '1;
      ierQ <= '0;
    end else begin
      if (stb.wrMask)   imrQ <= wrData;
      if (stb.wrEnable) ierQ <= wrData;
    end
  end

  for (genvar b = 0; b < NSRC; b++) begin : g_cell
    qirq_cell cell_i (
      .clk     (clk),
      .rstN    (rstN),
      .evIn    (srcEvent[b]),
      .maskBit (imrQ[b]),
      .clrIn   (stb.clrIdent & wrData[b]),
      .visOut  (identVis[b]),
      .qdOut   (identQd[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |(identVis & ierQ);
  end
  assign irqOut = irqQ;

  always_comb begin
    unique case (rdSel)
      SEL_IDENT:  rdData = identVis;
      SEL_MASK:   rdData = imrQ;
      SEL_ENABLE: rdData = ierQ;
      default:    rdData = '0;
    endcase
  end

  // R7
  enable_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ierQ == '0) |=> !irqOut);
  // R6
  level_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(identVis & ierQ)) |=> irqOut);
  // R6
  level_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(|(identVis & ierQ)) |=> !irqOut);
  // R10
  mask_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrMask |=> (imrQ == $past(wrData)));
  // R9
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrMask, stb.wrEnable, stb.clrIdent}));
  // R4
  queue_subset_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((identQd & ~identVis) == '0));
endmodule

// File: rtl/qirq_bank.sv
module qirq_bank
  import qirq_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSRC-1:0]   srcEvent,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [NSRC-1:0]   regWrData,
  output logic [NSRC-1:0]   regRdData,
  output logic              irqOut
);
  bankStrobe_t stb;
  regSel_e     rdSel;

  qirq_ctrl ctrl_i (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .stb     (stb),
    .rdSel   (rdSel)
  );

  qirq_datapath #(.NSRC(NSRC)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .srcEvent (srcEvent),
    .stb      (stb),
    .rdSel    (rdSel),
    .wrData   (regWrData),
    .rdData   (regRdData),
    .irqOut   (irqOut)
  );
endmodule

// File: tb/qirq_bank_tb.sv
module qirq_bank_tb_top;
  localparam int N = 32;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rstN;
  logic [N-1:0] srcEvent;
  logic         regWrEn;
  logic [1:0]   regAddr;
  logic [N-1:0] regWrData;
  logic [N-1:0] regRdData;
  logic         irqOut;

  int checks = 0;
  int failures = 0;

  logic [N-1:0] mVis, mQd, mMask, mEn;
  logic         mIrq;

  always #(CLK_PERIOD/2) clk = ~clk;

  qirq_bank #(.NSRC(N)) dut_i (
    .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Update the bench model using the values held before the edge.
  task automatic modelEdge(input logic [N-1:0] ev, input logic we,
                           input logic [1:0] a, input logic [N-1:0] d);
    logic nIrq;
    nIrq = |(mVis & mEn);
    for (int i = 0; i < N; i++) begin
      if (ev[i] && !mMask[i]) begin
        if (!mVis[i]) mVis[i] = 1'b1;
        else          mQd[i]  = 1'b1;
      end else if (we && a == 2'd0 && d[i]) begin
        mVis[i] = mQd[i];
        mQd[i]  = 1'b0;
      end
    end
    if (we && a == 2'd1) mMask = d;
    if (we && a == 2'd2) mEn = d;
    mIrq = nIrq;
  endtask

  // Inputs are driven at a falling edge; the model advances at the rising edge.
  task automatic step(input logic [N-1:0] ev, input logic we,
                      input logic [1:0] a, input logic [N-1:0] d);
    srcEvent = ev; regWrEn = we; regAddr = a; regWrData = d;
    @(posedge clk);
    modelEdge(ev, we, a, d);
    @(negedge clk);
    srcEvent = '0; regWrEn = 1'b0; regAddr = 2'd0; regWrData = '0;
  endtask

  task automatic idle();
    step('0, 1'b0, 2'd0, '0);
  endtask

  task automatic readReg(input logic [1:0] a, output logic [N-1:0] v);
    regAddr = a;
    #1;
    v = regRdData;
    regAddr = 2'd0;
    #1;
  endtask

  task automatic checkAll(input string tag);
    logic [N-1:0] v;
    readReg(2'd0, v); chk({tag, " ident"}, v, mVis);
    readReg(2'd1, v); chk({tag, " mask"}, v, mMask);
    readReg(2'd2, v); chk({tag, " enable"}, v, mEn);
    chk({tag, " irq"}, {{(N-1){1'b0}}, irqOut}, {{(N-1){1'b0}}, mIrq});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [N-1:0] r1, r2, r3;
    void'($urandom(32'h5eed_1234));
    srcEvent = '0; regWrEn = 1'b0; regAddr = 2'd0; regWrData = '0;
    rstN = 1'b0;
    mVis = '0; mQd = '0; mMask = '1; mEn = '0; mIrq = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkAll("R1");

    // R2: every source blocked by the reset mask
    step('1, 1'b0, 2'd0, '0);
    idle();
    checkAll("R2 all-masked");

    // Bring-up: enable first, then mask (R10)
    step('0, 1'b1, 2'd2, '1);
    step('0, 1'b1, 2'd1, '0);
    checkAll("R10 program");

    // R2 and R6: single event, then the level one cycle later
    step(32'h1, 1'b0, 2'd0, '0);
    checkAll("R2 latch");
    idle();
    checkAll("R6 level");

    // R4: second event waits; two clears drain the bit
    step(32'h1, 1'b0, 2'd0, '0);
    step('0, 1'b1, 2'd0, 32'h1);
    checkAll("R4 promote");
    step('0, 1'b1, 2'd0, 32'h1);
    idle();
    checkAll("R4 drained");

    // R3: zeros leave bits alone, ones clear
    step(32'h8, 1'b0, 2'd0, '0);
    step('0, 1'b1, 2'd0, '0);
    checkAll("R3 zero-write");
    step('0, 1'b1, 2'd0, ~32'h8);
    checkAll("R3 other-bits");
    step('0, 1'b1, 2'd0, 32'h8);
    idle();
    checkAll("R3 cleared");

    // R5: an event coinciding with a clear wins
    step(32'h20, 1'b0, 2'd0, '0);
    step(32'h20, 1'b1, 2'd0, 32'h20);
    checkAll("R5 same-cycle");
    step('0, 1'b1, 2'd0, 32'h20);
    checkAll("R5 first-clear");
    step('0, 1'b1, 2'd0, 32'h20);
    checkAll("R5 second-clear");

    // R4: a third event on a full bit is lost
    step(32'h200, 1'b0, 2'd0, '0);
    step(32'h200, 1'b0, 2'd0, '0);
    step(32'h200, 1'b0, 2'd0, '0);
    step('0, 1'b1, 2'd0, 32'h200);
    step('0, 1'b1, 2'd0, 32'h200);
    idle();
    checkAll("R4 overflow");

    // R7: disable drops the line, re-enable raises it with a promoted bit pending
    step(32'h40, 1'b0, 2'd0, '0);
    step(32'h40, 1'b0, 2'd0, '0);
    step('0, 1'b1, 2'd2, '0);
    step('0, 1'b1, 2'd0, 32'h40);
    idle();
    checkAll("R7 disabled");
    step('0, 1'b1, 2'd2, '1);
    idle();
    checkAll("R7 re-enabled");
    step('0, 1'b1, 2'd0, 32'h40);
    idle();

    // R8: reads change nothing
    step(32'h1000, 1'b0, 2'd0, '0);
    readReg(2'd0, r1); readReg(2'd0, r2); readReg(2'd0, r3);
    chk("R8 reread", r2, r1);
    chk("R8 reread2", r3, r1);
    idle();
    checkAll("R8 after-reads");

    // R9: address 3 reads zero and ignores writes
    readReg(2'd3, r1);
    chk("R9 addr3 read", r1, '0);
    step('0, 1'b1, 2'd3, '1);
    checkAll("R9 addr3 write");
    step('0, 1'b1, 2'd0, '1);
    step('0, 1'b1, 2'd0, '1);

    // R2: partial mask, bit 7 blocked and bit 8 open
    step('0, 1'b1, 2'd1, 32'h80);
    step(32'h180, 1'b0, 2'd0, '0);
    checkAll("R2 partial");
    step('0, 1'b1, 2'd1, '0);
    step('0, 1'b1, 2'd0, 32'h100);
    checkAll("R2 masked-not-queued");

    // Random mix against the model
    for (int k = 0; k < 400; k++) begin
      logic [N-1:0] ev, d;
      logic we;
      logic [1:0] a;
      ev = $urandom & $urandom & $urandom;
      we = ($urandom % 3) == 0;
      a  = 2'($urandom % 4);
      d  = (a == 2'd0) ? 32'($urandom) : (($urandom % 4 == 0) ? '1 : 32'($urandom));
      step(ev, we, a, d);
      if (k % 8 == 0) checkAll("R4 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule